// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block gathers up to 32 interrupt request lines and presents one interrupt request to a processor. Each source has a status bit that records an event and an enable bit that masks it. A processor reaches the controller through a small word-addressed register bus. Through that bus it can do the following:

- write the enable mask directly, or set or clear selected enable bits without a read-modify-write;
- clear status bits by writing ones to an acknowledge register;
- read which sources are both active and enabled;
- read the index of the lowest-numbered such source;
- gate the processor request with a master enable.

The master register also carries a hardware-enable bit that cannot be cleared once set. Until that bit is set, the request inputs are ignored and software may write the status register directly, which lets software raise test interrupts. After it is set, only the inputs can set status bits.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the status, enable and master registers are zero. The interrupt output is low and the vector register reads all ones.
- R2: The register offsets are as follows. Status is at byte offset 0x00, pending at 0x04, enable at 0x08, acknowledge at 0x0C, set-enable at 0x10, clear-enable at 0x14, vector at 0x18 and master at 0x1C. Bit i of every per-source register belongs to input i, with input 0 at bit 0. While the hardware-enable bit is 0, a write to status loads it and the request inputs have no effect.
- R3: A write to the acknowledge register clears each status bit whose written bit is 1 and leaves the other status bits unchanged.
- R4: A write to the enable register loads the mask. A write to set-enable ORs the written mask into the enable bits, and a write to clear-enable clears the enable bits written as 1. Enable bits not named in the mask keep their value.
- R5: The pending register reads as status AND enable.
- R6: The vector register reads the index of the lowest-numbered pending source, or 0xFFFFFFFF when no source is pending.
- R7: In the master register, bit 0 is the master enable and bit 1 is the hardware enable. Bit 1 reads back as 1 from the first write that sets it until reset, whatever is written later.
- R8: While the hardware-enable bit is 1, a status bit is set in every cycle its input is high, and software writes to status are ignored. If an input is high in the same cycle its status bit is acknowledged, the bit stays set.
- R9: The interrupt output is registered. It is high in the cycle after one in which master bit 0 is 1 and at least one pending bit is 1, and low otherwise.
- R10: Register bits above the configured number of sources read as zero. A read of an offset outside 0x00 to 0x1C returns zero, and so does a read of an address that is not word aligned. Writes to such addresses change nothing.
- R11: Read data appears on the read-data port one cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_SRC | Active-high level interrupt requests |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The assertions take for granted that the bus never asserts read and write in the same cycle. They also assume each access is a single-cycle strobe with address and data stable in that cycle. The bench keeps to these assumptions by driving every access through one task, which changes inputs only at the falling clock edge and drops the strobe after one cycle. The assertion on the request inputs assumes that an input high in a cycle stands for a real event. So the bench leaves the inputs at zero, or drives them only while hardware mode is still off, except during the hardware-mode checks, where single-cycle pulses are placed on purpose.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int DATA_W   = 32;
  localparam int WORD_LSB = 2;
  localparam int WIN_MSB  = 4;

  typedef enum logic [2:0] {
    RG_STAT   = 3'd0,
    RG_PEND   = 3'd1,
    RG_ENAB   = 3'd2,
    RG_ACK    = 3'd3,
    RG_SETEN  = 3'd4,
    RG_CLREN  = 3'd5,
    RG_VEC    = 3'd6,
    RG_MASTER = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic stat;
    logic ack;
    logic enab;
    logic seten;
    logic clren;
    logic master;
  } wr_strobe_t;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              in_window,
  output reg_sel_e          sel,
  output wr_strobe_t        strb
);

  logic upper_zero;

  generate
    if (ADDR_W > WIN_MSB + 1) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:WIN_MSB+1] == '0);
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign in_window = upper_zero && (addr[WORD_LSB-1:0] == '0);
  assign sel       = reg_sel_e'(addr[WIN_MSB:WORD_LSB]);

  always_comb begin
    strb        = '0;
    if (wr && in_window) begin
      strb.stat   = (sel == RG_STAT);
      strb.ack    = (sel == RG_ACK);
      strb.enab   = (sel == RG_ENAB);
      strb.seten  = (sel == RG_SETEN);
      strb.clren  = (sel == RG_CLREN);
      strb.master = (sel == RG_MASTER);
    end
  end

endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hw_en,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] wmask,
  input  logic               st_wr,
  input  logic               ack_wr,
  output logic [NUM_SRC-1:0] stat
);

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_bit
      logic clr;
      assign clr = ack_wr && wmask[i];

      always_ff @(posedge clk) begin
        if (rst) begin
          stat[i] <= 1'b0;
        end else if (hw_en) begin
          stat[i] <= irq_in[i] | (stat[i] & ~clr);
        end else if (st_wr) begin
          stat[i] <= wmask[i];
        end else if (clr) begin
          stat[i] <= 1'b0;
        end
      end

      // R8: an input event beats a same-cycle acknowledge in hardware mode
      a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (hw_en && irq_in[i]) |=> stat[i]);

      // R3: acknowledge clears the bit when no input event can set it
      a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (!hw_en && ack_wr && wmask[i]) |=> !stat[i]);
    end
  endgenerate

  // R2: in software mode, status only moves on a bus write
  a_r2_inputs_ignored: assert property (@(posedge clk) disable iff (rst)
    (!hw_en && !st_wr && !ack_wr) |=> $stable(stat));

endmodule

// File: rtl/irqc_first.sv
module irqc_first #(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    found = |pend;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               irq_out
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               in_window;
  reg_sel_e           sel;
  wr_strobe_t         strb;
  logic [NUM_SRC-1:0] wmask;
  logic [NUM_SRC-1:0] stat;
  logic [NUM_SRC-1:0] enab;
  logic [NUM_SRC-1:0] pend;
  logic               mst_en;
  logic               hw_en;
  logic               vec_found;
  logic [IDX_W-1:0]   vec_idx;
  logic [DATA_W-1:0]  rd_val;
  logic               irq_q;
  logic [DATA_W-1:0]  rdata_q;

  assign wmask = bus_wdata[NUM_SRC-1:0];

  irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr      (bus_addr),
    .wr        (bus_wr),
    .in_window (in_window),
    .sel       (sel),
    .strb      (strb)
  );

  irqc_status #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .hw_en  (hw_en),
    .irq_in (irq_in),
    .wmask  (wmask),
    .st_wr  (strb.stat),
    .ack_wr (strb.ack),
    .stat   (stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enab <= '0;
    end else if (strb.enab) begin
      enab <= wmask;
    end else if (strb.seten) begin
      enab <= enab | wmask;
    end else if (strb.clren) begin
      enab <= enab & ~wmask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mst_en <= 1'b0;
      hw_en  <= 1'b0;
    end else if (strb.master) begin
      mst_en <= bus_wdata[0];
      hw_en  <= hw_en | bus_wdata[1];
    end
  end

  assign pend = stat & enab;

  irqc_first #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_first (
    .pend  (pend),
    .found (vec_found),
    .idx   (vec_idx)
  );

  always_comb begin
    rd_val = '0;
    if (in_window) begin
      case (sel)
        RG_STAT:   rd_val[NUM_SRC-1:0] = stat;
        RG_PEND:   rd_val[NUM_SRC-1:0] = pend;
        RG_ENAB:   rd_val[NUM_SRC-1:0] = enab;
        RG_VEC: begin
          if (vec_found) rd_val[IDX_W-1:0] = vec_idx;
          else           rd_val = '1;
        end
        RG_MASTER: rd_val[1:0] = {hw_en, mst_en};
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rd_val;
      irq_q <= mst_en && (|pend);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

  // R7: the hardware-enable bit never falls outside reset
  a_r7_hw_sticky: assert property (@(posedge clk) disable iff (rst)
    hw_en |=> hw_en);

  // R9: request follows master enable and pending one cycle later
  a_r9_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (mst_en && (|pend)) |=> irq_out);
  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (!mst_en || !(|pend)) |=> !irq_out);

  // R4: a set-enable write leaves every named bit enabled
  a_r4_seten_sets: assert property (@(posedge clk) disable iff (rst)
    strb.seten |=> ((enab & $past(wmask)) == $past(wmask)));

  // R10: reads outside the map return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !in_window) |=> (bus_rdata == '0));

  // R6: a reported vector always names a pending source
  a_r6_vec_pending: assert property (@(posedge clk) disable iff (rst)
    vec_found |-> pend[vec_idx]);

endmodule

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;

  localparam int N  = 5;
  localparam int AW = 8;

  localparam logic [AW-1:0] A_STAT  = 8'h00;
  localparam logic [AW-1:0] A_PEND  = 8'h04;
  localparam logic [AW-1:0] A_ENAB  = 8'h08;
  localparam logic [AW-1:0] A_ACK   = 8'h0C;
  localparam logic [AW-1:0] A_SETEN = 8'h10;
  localparam logic [AW-1:0] A_CLREN = 8'h14;
  localparam logic [AW-1:0] A_VEC   = 8'h18;
  localparam logic [AW-1:0] A_MAST  = 8'h1C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_in = '0;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] lowest(input logic [N-1:0] p);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = N - 1; i >= 0; i--) if (p[i]) r = i;
    return r;
  endfunction

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    rd(A_STAT, d);  chk("R1 status", d, 32'h0);
    rd(A_ENAB, d);  chk("R1 enable", d, 32'h0);
    rd(A_MAST, d);  chk("R1 master", d, 32'h0);
    rd(A_VEC, d);   chk("R1 vector", d, 32'hFFFF_FFFF);

    // R2 inputs ignored in software mode
    irq_in = '1;
    repeat (4) @(negedge clk);
    rd(A_STAT, d);  chk("R2 inputs ignored", d, 32'h0);
    irq_in = '0;
    wr(A_STAT, 32'h0000_0016);
    rd(A_STAT, d);  chk("R2 status write", d, 32'h16);

    // R3 acknowledge
    wr(A_STAT, 32'h0000_0017);
    wr(A_ACK, 32'h0000_0005);
    rd(A_STAT, d);  chk("R3 ack clears ones only", d, 32'h12);
    wr(A_ACK, 32'h0);
    rd(A_STAT, d);  chk("R3 ack zero no effect", d, 32'h12);

    // R4 enable aliases
    wr(A_SETEN, 32'h09);
    rd(A_ENAB, d);  chk("R4 set-enable", d, 32'h09);
    wr(A_SETEN, 32'h02);
    rd(A_ENAB, d);  chk("R4 set-enable keeps", d, 32'h0B);
    wr(A_CLREN, 32'h08);
    rd(A_ENAB, d);  chk("R4 clear-enable", d, 32'h03);
    wr(A_ENAB, 32'h14);
    rd(A_ENAB, d);  chk("R4 direct load", d, 32'h14);

    // R10 unused bits and unmapped addresses
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d);  chk("R10 upper bits zero", d, 32'h1F);
    rd(8'h20, d);   chk("R10 offset 0x20", d, 32'h0);
    rd(8'h41, d);   chk("R10 offset 0x41", d, 32'h0);
    rd(8'h01, d);   chk("R10 misaligned", d, 32'h0);
    wr(8'h09, 32'h0);
    rd(A_ENAB, d);  chk("R10 misaligned write ignored", d, 32'h14);
    wr(8'h28, 32'h0);
    rd(A_ENAB, d);  chk("R10 unmapped write ignored", d, 32'h14);

    // R9 master gating and latency
    wr(A_ENAB, 32'h01);
    wr(A_STAT, 32'h01);
    @(negedge clk);
    chk("R9 master off", {31'b0, irq_out}, 32'h0);
    wr(A_MAST, 32'h1);
    chk("R9 one cycle latency", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R9 raised", {31'b0, irq_out}, 32'h1);

    // R5 R6 R9 R11 exhaustive sweep over enable and status
    for (int e = 0; e < 32; e++) begin
      wr(A_ENAB, e);
      for (int s = 0; s < 32; s++) begin
        logic [N-1:0] p;
        p = N'(s) & N'(e);
        wr(A_STAT, s);
        rd(A_PEND, d); chk("R5 R11 pending", d, {27'b0, p});
        rd(A_VEC, d);  chk("R6 vector", d, lowest(p));
        chk("R9 irq level", {31'b0, irq_out}, {31'b0, |p});
      end
    end

    // R7 sticky hardware enable
    wr(A_MAST, 32'h2);
    rd(A_MAST, d);  chk("R7 hw set", d, 32'h2);
    wr(A_MAST, 32'h0);
    rd(A_MAST, d);  chk("R7 hw sticky", d, 32'h2);
    wr(A_MAST, 32'h1);
    rd(A_MAST, d);  chk("R7 master with hw", d, 32'h3);

    // R8 hardware mode
    wr(A_ENAB, 32'h1F);
    wr(A_ACK, 32'h1F);
    rd(A_STAT, d);  chk("R8 cleared", d, 32'h0);
    wr(A_STAT, 32'h1F);
    rd(A_STAT, d);  chk("R8 status write ignored", d, 32'h0);
    @(negedge clk); irq_in = 5'b00100;
    @(negedge clk); irq_in = '0;
    rd(A_STAT, d);  chk("R8 input sets", d, 32'h04);
    rd(A_VEC, d);   chk("R8 R6 vector", d, 32'h2);
    @(negedge clk);
    irq_in = 5'b00010; bus_addr = A_ACK; bus_wdata = 32'h02; bus_wr = 1'b1;
    @(negedge clk);
    irq_in = '0; bus_wr = 1'b0;
    rd(A_STAT, d);  chk("R8 set beats ack", d, 32'h06);
    wr(A_ACK, 32'h06);
    rd(A_STAT, d);  chk("R8 ack after input low", d, 32'h0);
    @(negedge clk);
    chk("R9 drops", {31'b0, irq_out}, 32'h0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule